// File: doc/BRIEF.md
# One-Shot Reseedable LFSR with Serial Seed Crossing

This block is a 24-bit pseudo-random generator that runs on its own clock. Reset puts a fixed seed into it. After reset, an external controller may send one 24-bit seed over a simple clocked serial link that runs on a second, unrelated clock. The generator takes that seed once. It then ignores every later serial word until the next reset.

The seed word never reaches the generator registers through a combinational path from the serial clock domain. When the serial side completes a word, it freezes the word in a register and flips a request toggle. The generator domain passes that toggle through two flip-flops. On a detected edge, it copies the frozen word into a holding register clocked by its own clock and returns an acknowledge toggle. One cycle later it loads the holding register into the generator, provided the one-shot flag is still clear. A status output shows whether the reseed has taken place.

Top module: `rseed_lfsr`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `lfsr_q` equals the parameter `SEED` (default 24'h9E3779) and `reseeded` is 0.
- R2: At each `clk` edge with no load, `advance` high replaces `lfsr_q` with `{lfsr_q[22:0],1'b0}`. If the old bit 23 was 1, that value is also XORed with 24'hC20001, which encodes x^24+x^23+x^22+x^17+1. With `advance` low, `lfsr_q` holds its value.
- R3: `s_din` is sampled on rising `s_clk` edges while `s_en` is high, most significant bit first. The 24th consecutive sampled bit completes a word. Taking `s_en` low discards a partial word.
- R4: The first word completed after reset appears on `lfsr_q` within 10 `clk` cycles after its last bit. `reseeded` rises in the same cycle. On that cycle the load takes priority over `advance`.
- R5: Once `reseeded` is 1, it stays 1 until reset. No later serial word changes `lfsr_q`: from then on, only `advance` moves it.
- R6: A completed all-zero word loads `SEED` instead of zero, so `lfsr_q` is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generator clock |
| rst_n | input | 1 | Asynchronous active-low reset, generator domain |
| s_clk | input | 1 | Serial link clock, asynchronous to clk |
| s_rst_n | input | 1 | Asynchronous active-low reset, serial domain |
| s_en | input | 1 | Frame enable; high while bits are shifted |
| s_din | input | 1 | Serial data, MSB first |
| advance | input | 1 | Step the generator once this cycle |
| lfsr_q | output | 24 | Generator state |
| reseeded | output | 1 | The one-time reseed has happened |

## Verification
The generator load and a generator step can land on the same `clk` edge. The bench provokes this by holding `advance` high without pause while a seed word crosses. The monitor therefore sees, in one cycle, the seed itself rather than a stepped value. It then expects stepping to continue from that seed on the next cycle. Later serial words are sent while `advance` keeps running. Any reload then shows up as a departure from the bench's own stepped sequence.

// File: rtl/rseed_lfsr.sv
module rseed_lfsr #(
  parameter int          W    = 24,
  parameter logic [23:0] SEED = 24'h9E3779,
  parameter logic [23:0] TAPS = 24'hC20001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_clk,
  input  logic         s_rst_n,
  input  logic         s_en,
  input  logic         s_din,
  input  logic         advance,
  output logic [W-1:0] lfsr_q,
  output logic         reseeded
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  s_sh, s_word;
  logic [CW-1:0] s_cnt;
  logic          s_req, s_ack_m, s_ack_s;
  wire           s_last = s_en && (s_cnt == CW'(W - 1));
  wire           s_idle = (s_req == s_ack_s);

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      s_sh    <= '0;
      s_word  <= '0;
      s_cnt   <= '0;
      s_req   <= 1'b0;
      s_ack_m <= 1'b0;
      s_ack_s <= 1'b0;
    end else begin
      s_ack_m <= ack;
      s_ack_s <= s_ack_m;
      if (!s_en) s_cnt <= '0;
      else begin
        s_sh  <= {s_sh[W-2:0], s_din};
        s_cnt <= s_last ? '0 : s_cnt + 1'b1;
        if (s_last && s_idle) begin
          s_word <= {s_sh[W-2:0], s_din};
          s_req  <= ~s_req;
        end
      end
    end
  end

  logic         req_m, req_s, req_d, ack, load_pend;
  logic [W-1:0] hold;
  wire          req_edge = req_s ^ req_d;
  wire  [W-1:0] stepped  = {lfsr_q[W-2:0], 1'b0} ^ (lfsr_q[W-1] ? TAPS[W-1:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_m     <= 1'b0;
      req_s     <= 1'b0;
      req_d     <= 1'b0;
      ack       <= 1'b0;
      hold      <= '0;
      load_pend <= 1'b0;
      lfsr_q    <= SEED[W-1:0];
      reseeded  <= 1'b0;
    end else begin
      req_m     <= s_req;
      req_s     <= req_m;
      req_d     <= req_s;
      load_pend <= req_edge;
      if (req_edge) begin
        hold <= s_word;
        ack  <= req_s;
      end
      if (load_pend && !reseeded) begin
        lfsr_q   <= (hold == '0) ? SEED[W-1:0] : hold;
        reseeded <= 1'b1;
      end else if (advance) begin
        lfsr_q <= stepped;
      end
    end
  end
endmodule

module rseed_lfsr_chk #(parameter int W = 24) (
  input logic         clk,
  input logic         rst_n,
  input logic         s_clk,
  input logic         s_rst_n,
  input logic         advance,
  input logic [W-1:0] lfsr_q,
  input logic         reseeded,
  input logic         load_pend,
  input logic         s_req,
  input logic         s_ack_s,
  input logic [W-1:0] s_word
);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    reseeded |=> reseeded);
  a_r5_frozen_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (reseeded && !advance) |=> $stable(lfsr_q));
  a_r4_load_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reseeded) |-> $past(load_pend));
  a_r6_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
  a_r3_word_held: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (s_req != s_ack_s) |=> $stable(s_word));
endmodule

bind rseed_lfsr rseed_lfsr_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .s_clk(s_clk), .s_rst_n(s_rst_n),
  .advance(advance), .lfsr_q(lfsr_q), .reseeded(reseeded),
  .load_pend(load_pend), .s_req(s_req), .s_ack_s(s_ack_s), .s_word(s_word));

// File: tb/rseed_lfsr_tb_top.sv
module rseed_lfsr_tb_top;
  localparam logic [23:0] SEED = 24'h9E3779;
  localparam logic [23:0] TAPS = 24'hC20001;

  logic clk = 0, s_clk = 0, rst_n = 0, s_rst_n = 0;
  logic s_en = 0, s_din = 0, advance = 0;
  logic [23:0] lfsr_q;
  logic reseeded;
  int checks = 0, errors = 0;
  logic [23:0] exp_q[$];
  logic [23:0] model;
  logic prev_rs = 0;
  bit   mon_on = 0;
  int   since_last = -1;
  int   lat_seen = -1;

  always #2 clk = ~clk;
  always #7 s_clk = ~s_clk;

  rseed_lfsr dut_i (.clk(clk), .rst_n(rst_n), .s_clk(s_clk), .s_rst_n(s_rst_n),
    .s_en(s_en), .s_din(s_din), .advance(advance), .lfsr_q(lfsr_q), .reseeded(reseeded));

  function automatic logic [23:0] nxt(input logic [23:0] v);
    return {v[22:0], 1'b0} ^ (v[23] ? TAPS : 24'h0);
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: scoreboard against bench model
  always @(negedge clk) begin
    if (!rst_n) begin
      model = SEED;
      prev_rs = 0;
    end else if (mon_on) begin
      if (since_last >= 0) since_last++;
      if (reseeded && !prev_rs) begin
        if (exp_q.size() == 0) check(0, "R5 unexpected reseed", lfsr_q, model);
        else begin
          model = exp_q.pop_front();
          check(lfsr_q == model, "R4/R6 seed loaded", lfsr_q, model);
          lat_seen = since_last;
        end
      end else begin
        check(lfsr_q == model, "R2/R5 sequence", lfsr_q, model);
      end
      if (prev_rs && !reseeded) check(0, "R5 reseeded fell", {23'd0, reseeded}, 24'd1);
      prev_rs = reseeded;
      if (advance) model = nxt(model);
    end
  end

  task automatic send_bits(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge s_clk);
      s_en = 1; s_din = w[23 - i];
    end
    @(negedge s_clk);
    s_en = 0;
  endtask

  task automatic send_word(input logic [23:0] w, input bit expect_load, input logic [23:0] ld);
    if (expect_load) exp_q.push_back(ld);
    send_bits(w, 24);
    since_last = 0;
  endtask

  task automatic do_reset;
    @(posedge clk); #1;
    mon_on = 0; rst_n = 0; s_rst_n = 0; advance = 0;
    repeat (3) @(posedge clk);
    #1;
    check(lfsr_q == SEED, "R1 reset value", lfsr_q, SEED);
    check(reseeded == 0, "R1 reseeded low", {23'd0, reseeded}, 24'd0);
    rst_n = 1; s_rst_n = 1;
    mon_on = 1;
    exp_q.delete();
  endtask

  task automatic run(input int n, input bit adv);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; advance = adv;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    run(40, 1);                      // R2 stepping
    run(20, 0);                      // R2 hold
    run(5, 1);
    // R3: partial frame discarded, then full word; R4 load while advancing
    send_bits(24'hFFFFFF, 10);
    send_word(24'h5A3C81, 1, 24'h5A3C81);
    run(30, 1);
    check(reseeded == 1, "R4 reseeded set", {23'd0, reseeded}, 24'd1);
    check(lat_seen >= 0 && lat_seen <= 10, "R4 latency", 24'(lat_seen), 24'd10);
    // R5: later words ignored
    send_word(24'h123456, 0, 24'h0);
    run(30, 0);
    send_word(24'h000001, 0, 24'h0);
    run(30, 1);
    check(reseeded == 1, "R5 reseeded stays", {23'd0, reseeded}, 24'd1);
    // R6: zero seed replaced
    do_reset();
    run(10, 1);
    lat_seen = -1;
    send_word(24'h000000, 1, SEED);
    run(30, 1);
    check(exp_q.size() == 0, "R6 zero-seed load seen", 24'(exp_q.size()), 24'd0);
    check(lat_seen >= 0 && lat_seen <= 10, "R4 latency second", 24'(lat_seen), 24'd10);
    // R4 without advance, MSB-first check
    do_reset();
    run(3, 0);
    send_word(24'h800003, 1, 24'h800003);
    run(20, 0);
    check(lfsr_q == 24'h800003, "R3 MSB first", lfsr_q, 24'h800003);
    run(1, 1);
    run(1, 0);
    run(3, 0);
    check(lfsr_q == nxt(24'h800003), "R2 step with msb set", lfsr_q, nxt(24'h800003));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule